// File: doc/BRIEF.md
# Addressable LED stream receiver

This block sits on the single data wire that a controller uses to drive a chain of RGB addressable LEDs. It recovers the pulse-width-coded bit stream and packs each group of 24 bits into one colour word for the LED it addresses. A long stretch of low level on the wire is the boundary between frames. The block recognises that boundary and tags the next word so that a later stage can rebuild the frame boundaries in order.

The line is first brought into the system clock domain. The width of each high pulse, counted in system clocks, decides whether the bit is a zero or a one. The wire carries the colours in green, red, blue order, most significant bit first. The block reorders them to red, green, blue. Each finished word leaves with a one-cycle write strobe toward a dual-port FIFO, together with a start-of-frame flag bit. Frame detection cannot happen sooner than the full low threshold, so every frame boundary costs that much dead time on the wire.

Top module: `led_stream_rx`

## Requirements
- R1: While and right after reset, `fifo_wr` and `fifo_sof` are 0 and `fifo_rgb` is all zeros.
- R2: A high pulse lasting ONE_MIN_CLKS (8) or more clock cycles decodes as a 1. A pulse lasting 7 cycles or fewer decodes as a 0.
- R3: A line that stays low for RESET_CLKS (600, which is 50 us at 12 MHz) consecutive cycles marks a frame boundary. A low stretch of 599 cycles does not mark one, and the word in progress continues.
- R4: When a frame boundary is detected, any partially received bits are discarded and the bit counter starts again from zero.
- R5: After 24 bits arrive as G[7:0], R[7:0], B[7:0] (each byte MSB first), `fifo_wr` pulses for one cycle. At the same time `fifo_rgb` = {R, G, B}, with R in bits 23:16 and B in bits 7:0.
- R6: The first word after a frame boundary carries `fifo_sof` = 1, and only that word does. Several boundaries with no complete word between them still give a single flagged word. `fifo_sof` is never 1 without `fifo_wr`.
- R7: Words that follow each other with no frame boundary between them carry `fifo_sof` = 0, and each one is decoded independently.
- R8: An idle low line after reset counts toward a frame boundary, so the first word of the first frame is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| led_in | input | 1 | Asynchronous serial LED data line |
| fifo_wr | output | 1 | One-cycle write strobe for a completed word |
| fifo_rgb | output | 3*CH_W | Colour word {R, G, B} |
| fifo_sof | output | 1 | Set on the first word after a frame boundary |

## Verification
The bench places pulses on both sides of the threshold (7, 8 and 9 high cycles). A decoder with an off-by-one comparison would flip those bits and corrupt the word values. It holds low gaps of exactly 599 and exactly 600 cycles. A low counter that is off by one would either split a word in the middle or miss a boundary, and would show up as a wrong colour or a wrong flag. It breaks off a frame partway through a word and also sends two boundaries in a row. A design that kept stale bits would emit shifted colours. A design that did not merge pending flags, or did not clear them, would flag extra words or produce surplus writes.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    // One decoded bit handed from the pulse timer to the word packer
    typedef struct packed {
        logic vld;
        logic val;
    } lsr_bit_t;

endpackage

// File: rtl/lsr_sync_edge.sv
module lsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.chain[STAGES-1];
    assign fall  = st_q.prev & ~st_q.chain[STAGES-1];

    initial begin
        if (STAGES < 2) $error("lsr_sync_edge needs at least two stages");
    end
endmodule

// File: rtl/lsr_pulse_timer.sv
module lsr_pulse_timer
    import lsr_pkg::*;
#(
    parameter int ONE_MIN    = 8,
    parameter int RESET_CLKS = 600
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     level,
    input  logic     fall,
    output lsr_bit_t bit_o,
    output logic     frame_pls
);
    localparam int HI_W = $clog2(ONE_MIN + 1);
    localparam int LO_W = $clog2(RESET_CLKS + 1);
    localparam logic [HI_W-1:0] HI_SAT  = HI_W'(ONE_MIN);
    localparam logic [LO_W-1:0] LO_SAT  = LO_W'(RESET_CLKS);
    localparam logic [LO_W-1:0] LO_LAST = LO_W'(RESET_CLKS - 1);

    typedef struct packed {
        logic [HI_W-1:0] hi_cnt;
        logic [LO_W-1:0] lo_cnt;
        lsr_bit_t        bit_out;
        logic            frame;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d             = st_q;
        st_d.bit_out.vld = 1'b0;
        st_d.frame       = 1'b0;
        if (level) begin
            st_d.lo_cnt = '0;
            if (st_q.hi_cnt != HI_SAT) st_d.hi_cnt = st_q.hi_cnt + 1'b1;
        end else begin
            st_d.hi_cnt = '0;
            if (st_q.lo_cnt != LO_SAT) begin
                st_d.lo_cnt = st_q.lo_cnt + 1'b1;
                if (st_q.lo_cnt == LO_LAST) st_d.frame = 1'b1;
            end
        end
        if (fall) begin
            st_d.bit_out.vld = 1'b1;
            st_d.bit_out.val = (st_q.hi_cnt >= HI_SAT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o     = st_q.bit_out;
    assign frame_pls = st_q.frame;

    AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.frame |=> !st_q.frame);                                   // R3
    AST_HIGH_BLOCKS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        level |=> !st_q.frame);                                        // R3
    AST_BIT_FRAME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.bit_out.vld && st_q.frame));                            // R4
endmodule

// File: rtl/lsr_word_pack.sv
module lsr_word_pack
    import lsr_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lsr_bit_t            bit_i,
    input  logic                frame_pls,
    output logic                wr,
    output logic [3*CH_W-1:0]   rgb,
    output logic                sof
);
    localparam int WORD_BITS = 3 * CH_W;
    localparam int CNT_W     = $clog2(WORD_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_BITS - 1);

    typedef struct packed {
        logic [WORD_BITS-1:0] sr;
        logic [CNT_W-1:0]     cnt;
        logic                 sof_pend;
        logic                 wr;
        logic                 sof;
        logic [WORD_BITS-1:0] rgb;
    } st_t;

    st_t st_q, st_d;
    logic [WORD_BITS-1:0] sr_next;

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        st_d.sof = 1'b0;
        sr_next  = {st_q.sr[WORD_BITS-2:0], bit_i.val};
        if (frame_pls) begin
            st_d.cnt      = '0;
            st_d.sof_pend = 1'b1;
        end else if (bit_i.vld) begin
            st_d.sr = sr_next;
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt      = '0;
                st_d.wr       = 1'b1;
                st_d.sof      = st_q.sof_pend;
                st_d.sof_pend = 1'b0;
                // wire order G,R,B -> output order R,G,B
                st_d.rgb      = {sr_next[2*CH_W-1:CH_W],
                                 sr_next[3*CH_W-1:2*CH_W],
                                 sr_next[CH_W-1:0]};
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr  = st_q.wr;
    assign rgb = st_q.rgb;
    assign sof = st_q.sof;

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wr |=> !st_q.wr);                                         // R5
    AST_FRAME_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pls |=> (st_q.cnt == '0) && st_q.sof_pend);              // R4
    AST_SOF_ONLY_WR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sof |-> st_q.wr);                                         // R6
endmodule

// File: rtl/led_stream_rx.sv
module led_stream_rx
    import lsr_pkg::*;
#(
    parameter int CH_W         = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int ONE_MIN_CLKS = 8,
    parameter int RESET_CLKS   = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              led_in,
    output logic              fifo_wr,
    output logic [3*CH_W-1:0] fifo_rgb,
    output logic              fifo_sof
);
    logic     line_lvl;
    logic     line_fall;
    lsr_bit_t dec_bit;
    logic     frame_pls;

    lsr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (led_in),
        .level (line_lvl),
        .fall  (line_fall)
    );

    lsr_pulse_timer #(.ONE_MIN(ONE_MIN_CLKS), .RESET_CLKS(RESET_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (line_lvl),
        .fall      (line_fall),
        .bit_o     (dec_bit),
        .frame_pls (frame_pls)
    );

    lsr_word_pack #(.CH_W(CH_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (dec_bit),
        .frame_pls (frame_pls),
        .wr        (fifo_wr),
        .rgb       (fifo_rgb),
        .sof       (fifo_sof)
    );

    AST_SOF_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_sof |-> fifo_wr);                                         // R6
    AST_NO_BACK_TO_BACK_WR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |=> !fifo_wr);                                         // R7
endmodule

// File: tb/tb_led_stream_rx.sv
module tb_led_stream_rx;
    localparam int CLK_PERIOD = 84;
    localparam int T1H = 9;
    localparam int T0H = 4;
    localparam int TLO = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        led_in = 1'b0;
    logic        fifo_wr;
    logic [23:0] fifo_rgb;
    logic        fifo_sof;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [24:0] expq[$];

    led_stream_rx dut (
        .clk(clk), .rst_n(rst_n), .led_in(led_in),
        .fifo_wr(fifo_wr), .fifo_rgb(fifo_rgb), .fifo_sof(fifo_sof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic pulse(input int hi, input int lo);
        @(negedge clk) led_in = 1'b1;
        repeat (hi) @(negedge clk);
        led_in = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [23:0] v, input int hi_bit, input int lo_bit,
                             input int h1, input int h0);
        for (int i = hi_bit; i >= lo_bit; i--) pulse(v[i] ? h1 : h0, TLO);
    endtask

    function automatic logic [23:0] to_wire(input logic [23:0] rgb);
        return {rgb[15:8], rgb[23:16], rgb[7:0]};
    endfunction

    task automatic send_word(input logic [23:0] rgb, input logic sof,
                             input int h1, input int h0);
        expq.push_back({sof, rgb});
        send_bits(to_wire(rgb), 23, 0, h1, h0);
    endtask

    // monitor / scoreboard: R5 R6 R7
    always @(negedge clk) begin
        if (rst_n && fifo_wr) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected word: got %h sof %0d, expected none", fifo_rgb, fifo_sof);
            end else begin
                logic [24:0] e;
                e = expq.pop_front();
                if ({fifo_sof, fifo_rgb} !== e) begin
                    errors++;
                    $display("FAIL R5/R6 word: got sof %0d rgb %h, expected sof %0d rgb %h",
                             fifo_sof, fifo_rgb, e[24], e[23:0]);
                end
            end
        end
        if (rst_n && fifo_sof && !fifo_wr) begin
            checks++;
            errors++;
            $display("FAIL R6 sof without write: got 1, expected 0");
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset values
        checks++; if (fifo_wr !== 1'b0) begin errors++; $display("FAIL R1 fifo_wr: got %b expected 0", fifo_wr); end
        checks++; if (fifo_sof !== 1'b0) begin errors++; $display("FAIL R1 fifo_sof: got %b expected 0", fifo_sof); end
        checks++; if (fifo_rgb !== 24'h0) begin errors++; $display("FAIL R1 fifo_rgb: got %h expected 0", fifo_rgb); end
        rst_n = 1'b1;

        // R8: idle low after reset gives a boundary; first word flagged
        idle(700);
        send_word(24'h123456, 1'b1, T1H, T0H);
        // R7: consecutive words, no flag
        send_word(24'hA5C3F0, 1'b0, T1H, T0H);
        send_word(24'hFFFFFF, 1'b0, T1H, T0H);
        send_word(24'h000000, 1'b0, T1H, T0H);
        // R2: threshold 8 cycles -> 1, 7 cycles -> 0
        send_word(24'h8001FE, 1'b0, 8, 7);
        send_word(24'h5A5A5A, 1'b0, 8, 1);

        // R3: total low of 599 cycles mid-word is not a boundary
        expq.push_back({1'b0, 24'hC0FFEE});
        send_bits(to_wire(24'hC0FFEE), 23, 12, T1H, T0H);
        idle(599 - TLO - 1);
        send_bits(to_wire(24'hC0FFEE), 11, 0, T1H, T0H);

        // R3: total low of exactly 600 cycles is a boundary
        idle(600 - TLO - 1);
        send_word(24'h13579B, 1'b1, T1H, T0H);

        // R4: partial word then boundary; stale bits dropped
        send_bits(24'hFFFFFF, 23, 14, T1H, T0H);
        idle(700);
        send_word(24'h0F0F0F, 1'b1, T1H, T0H);

        // R6: two boundaries with a lone bit between give one flagged word
        idle(700);
        pulse(T1H, TLO);
        idle(700);
        send_word(24'h3C3C3C, 1'b1, T1H, T0H);

        idle(40);
        // R5: every expected word produced
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R5 pending words: got %0d left, expected 0", expq.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule